// File: doc/BRIEF.md
# Mode-Banked Register File with Packed PC and Status

This block holds the sixteen architectural registers of a small RISC core that runs in four processor modes. Registers 0 to 14 live in a physical array that is larger than the architectural view. The current mode selects which physical copy each register number reaches. The interrupt and supervisor modes swap in their own stack and link registers. The fast-interrupt mode swaps in a larger block of high registers, so its handler code can run without saving state.

Register 15 is not part of that array. It is a single word built from three fields: a 24-bit word counter that forms a 26-bit byte address, a 2-bit mode field, and six status flags. Read through a register port, it returns the whole word, mode bits included. Taken as the fetch address, it gives only the address, with the low two bits at zero. Around the array there are several ports:

- two combinational read ports;
- one write port;
- a branch/advance port that can also store a return address;
- a flag-update port;
- a mode-change request.

The flag port and the mode request both obey a privilege rule.

Top module: `moded_regbank`

## Requirements
- R1: After reset the mode is supervisor (3), I and F are both 1, N, Z, C and V are 0, the word counter is 0 and every banked register reads 0.
- R2: Modes are encoded user = 0, interrupt = 1, fast interrupt = 2, supervisor = 3. Reading register 15 on a read port returns the following fields, and `cur_mode` shows the mode:

  | Field | Bits |
  |---|---|
  | N | 31 |
  | Z | 30 |
  | C | 29 |
  | V | 28 |
  | I | 27 |
  | F | 26 |
  | word counter | 25:2 |
  | mode | 1:0 |

- R3: `fetch_addr` equals the word counter placed at bits 25:2, with bits 31:26 and 1:0 at zero.
- R4: In interrupt and supervisor modes, registers 13 and 14 reach a private copy per mode. All other numbers reach the user copies.
- R5: In fast-interrupt mode, registers 8 to 14 are private. With `REDUCED_FIQ` = 1, only registers 10 to 14 are private, and 8 and 9 reach the user copies.
- R6: In user mode, the mode field cannot change, whether through the mode request or through a write to register 15.
- R7: In user mode, I and F are left unchanged by both the flag port (`flag_in` bits 5..0 = N, Z, C, V, I, F) and a write to register 15, while N, Z, C, V and the word counter are updated.
- R8: A branch loads the word counter from `br_word`. With `br_link` set, it also writes register 15's current word, with the counter advanced by one, into register 14 of the current mode.
- R9: Register 15 updates with this priority: explicit write, then branch, then advance. An advance adds one word and wraps within 26 address bits.
- R10: A write is banked using the mode held at the start of its cycle. A mode change made in a cycle affects accesses from the following cycle.
- R11: The explicit write port wins over a link write to the same register, and a write to register 15 overrides the flag port and the mode request issued in the same cycle.
- R12: Both read ports are combinational and show any write from the cycle after it lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance the word counter by one |
| br_en | input | 1 | Load the word counter from br_word |
| br_link | input | 1 | With br_en, store the return word into register 14 |
| br_word | input | 24 | Branch target as a word index |
| flag_en | input | 1 | Flag update enable |
| flag_in | input | 6 | New flags N, Z, C, V, I, F (bit 5 down to 0) |
| mode_req_en | input | 1 | Mode change request |
| mode_req | input | 2 | Requested mode |
| fetch_addr | output | 32 | Instruction fetch byte address |
| cur_mode | output | 2 | Current mode |

## Verification
The bench targets these corner cases:

- **Same register number in different modes.** It writes and reads one register number across modes, and a wrong bank map shows up as one mode's stack value leaking into another.
- **Fast-interrupt boundary.** It probes registers 8, 9 and 12 on each side of a fast-interrupt entry, which exposes a boundary placed at the wrong register.
- **Same-cycle collisions.** It provokes a register 15 write together with a branch and an advance, a link together with an explicit register 14 write, and a mode change together with a register write. A design with the wrong priority or the wrong banking mode leaves a stale counter or puts data in the wrong bank.
- **User-mode privilege.** After dropping into user mode, it tries every path that could raise privilege or clear I and F; a leak shows as a changed mode or flag.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_IRQ = 2'b01,
    MODE_FIQ = 2'b10,
    MODE_SVC = 2'b11
  } rb_mode_e;

  localparam int RB_FLAG_W  = 6;
  localparam int RB_IDX_W   = 4;
  localparam int RB_PHYS_W  = 5;
  // physical layout: user 0..14, fast 15..21 (regs 8..14), irq 22..23, svc 24..25
  localparam int RB_NPHYS   = 26;
  localparam int RB_FIQ_OFS = 7;
  localparam int RB_IRQ_OFS = 9;
  localparam int RB_SVC_OFS = 11;

endpackage

// File: rtl/rb_bank_map.sv
module rb_bank_map
  import rb_pkg::*;
#(
  parameter bit REDUCED_FIQ = 1'b0
) (
  input  rb_mode_e               mode,
  input  logic [RB_IDX_W-1:0]    arch_idx,
  output logic [RB_PHYS_W-1:0]   phys_idx
);

  localparam logic [RB_IDX_W-1:0] FIQ_LO = REDUCED_FIQ ? 4'd10 : 4'd8;

  logic [RB_PHYS_W-1:0] wide_idx;
  assign wide_idx = RB_PHYS_W'(arch_idx);

  always_comb begin
    phys_idx = wide_idx;
    if (arch_idx == 4'd15) begin
      phys_idx = '0;
    end else begin
      case (mode)
        MODE_IRQ: if (arch_idx >= 4'd13) phys_idx = wide_idx + RB_PHYS_W'(RB_IRQ_OFS);
        MODE_SVC: if (arch_idx >= 4'd13) phys_idx = wide_idx + RB_PHYS_W'(RB_SVC_OFS);
        MODE_FIQ: if (arch_idx >= FIQ_LO) phys_idx = wide_idx + RB_PHYS_W'(RB_FIQ_OFS);
        default:  phys_idx = wide_idx;
      endcase
    end
  end

endmodule

// File: rtl/rb_gpr_store.sv
module rb_gpr_store
  import rb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPHYS = RB_NPHYS,
  parameter int NRD   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wa_en,
  input  logic [RB_PHYS_W-1:0]            wa_idx,
  input  logic [DW-1:0]                   wa_data,
  input  logic                            wb_en,
  input  logic [RB_PHYS_W-1:0]            wb_idx,
  input  logic [DW-1:0]                   wb_data,
  input  logic [NRD-1:0][RB_PHYS_W-1:0]   rd_idx,
  output logic [NRD-1:0][DW-1:0]          rd_data
);

  logic [NPHYS-1:0][DW-1:0] mem_q, mem_d;
  logic [NPHYS-1:0]         ent_en;

  // next state: port A (explicit) overrides port B (link)
  always_comb begin
    mem_d  = mem_q;
    ent_en = '0;
    for (int k = 0; k < NPHYS; k++) begin
      if (wb_en && (wb_idx == RB_PHYS_W'(k))) begin
        mem_d[k]  = wb_data;
        ent_en[k] = 1'b1;
      end
      if (wa_en && (wa_idx == RB_PHYS_W'(k))) begin
        mem_d[k]  = wa_data;
        ent_en[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int k = 0; k < NPHYS; k++) begin
        if (ent_en[k]) mem_q[k] <= mem_d[k];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem_q[rd_idx[p]];
  end

  assert_write_lands_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |=> mem_q[$past(wa_idx)] == $past(wa_data));

endmodule

// File: rtl/rb_r15_ctrl.sv
module rb_r15_ctrl
  import rb_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W+5:0]          wr_data,
  input  logic                       pc_inc,
  input  logic                       br_en,
  input  logic [ADDR_W-3:0]          br_word,
  input  logic                       flag_en,
  input  logic [RB_FLAG_W-1:0]       flag_in,
  input  logic                       mreq_en,
  input  logic [1:0]                 mreq,
  output logic [ADDR_W+5:0]          r15_word,
  output logic [ADDR_W+5:0]          link_word,
  output logic [ADDR_W+5:0]          fetch_addr,
  output rb_mode_e                   mode
);

  localparam int PC_W   = ADDR_W - 2;
  localparam int WORD_W = ADDR_W + RB_FLAG_W;

  rb_mode_e         mode_q, mode_d;
  logic [3:0]       nzcv_q, nzcv_d;
  logic [1:0]       if_q, if_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             priv, upd;

  assign priv = (mode_q != MODE_USR);
  assign upd  = wr_en | br_en | pc_inc | flag_en | mreq_en;

  always_comb begin
    mode_d = mode_q;
    nzcv_d = nzcv_q;
    if_d   = if_q;
    pc_d   = pc_q;
    if (wr_en) begin
      pc_d   = wr_data[ADDR_W-1:2];
      nzcv_d = wr_data[WORD_W-1 -: 4];
      if (priv) begin
        if_d   = wr_data[WORD_W-5 -: 2];
        mode_d = rb_mode_e'(wr_data[1:0]);
      end
    end else begin
      if (br_en)       pc_d = br_word;
      else if (pc_inc) pc_d = pc_q + PC_W'(1);
      if (flag_en) begin
        nzcv_d = flag_in[5:2];
        if (priv) if_d = flag_in[1:0];
      end
      if (mreq_en && priv) mode_d = rb_mode_e'(mreq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SVC;
      nzcv_q <= '0;
      if_q   <= 2'b11;
      pc_q   <= '0;
    end else if (upd) begin
      mode_q <= mode_d;
      nzcv_q <= nzcv_d;
      if_q   <= if_d;
      pc_q   <= pc_d;
    end
  end

  assign mode       = mode_q;
  assign r15_word   = {nzcv_q, if_q, pc_q, mode_q};
  assign link_word  = {nzcv_q, if_q, pc_q + PC_W'(1), mode_q};
  assign fetch_addr = {{RB_FLAG_W{1'b0}}, pc_q, 2'b00};

  assert_usr_mode_locked_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USR) |=> (mode_q == MODE_USR));

  assert_usr_if_locked_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USR) |=> $stable(if_q));

  assert_write_beats_inc_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pc_q == $past(wr_data[ADDR_W-1:2])));

  assert_pc_advance_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !wr_en && !br_en) |=> (pc_q == $past(pc_q) + PC_W'(1)));

  assert_branch_load_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (br_en && !wr_en) |=> (pc_q == $past(br_word)));

endmodule

// File: rtl/moded_regbank.sv
module moded_regbank
  import rb_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter bit REDUCED_FIQ = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           rd_a_idx,
  output logic [ADDR_W+5:0]    rd_a_data,
  input  logic [3:0]           rd_b_idx,
  output logic [ADDR_W+5:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [3:0]           wr_idx,
  input  logic [ADDR_W+5:0]    wr_data,
  input  logic                 pc_inc,
  input  logic                 br_en,
  input  logic                 br_link,
  input  logic [ADDR_W-3:0]    br_word,
  input  logic                 flag_en,
  input  logic [5:0]           flag_in,
  input  logic                 mode_req_en,
  input  logic [1:0]           mode_req,
  output logic [ADDR_W+5:0]    fetch_addr,
  output logic [1:0]           cur_mode
);

  localparam int WORD_W = ADDR_W + RB_FLAG_W;
  localparam int NRD    = 2;
  localparam int NMAP   = NRD + 2;   // read ports, write port, link target

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  rb_mode_e                          mode;
  logic [WORD_W-1:0]                 r15_word, link_word;
  logic [NMAP-1:0][RB_IDX_W-1:0]     arch_idx;
  logic [NMAP-1:0][RB_PHYS_W-1:0]    phys_idx;
  logic [NRD-1:0][RB_PHYS_W-1:0]     rd_phys;
  logic [NRD-1:0][WORD_W-1:0]        rd_store;
  logic [NRD-1:0][RB_IDX_W-1:0]      rd_arch;
  logic [NRD-1:0][WORD_W-1:0]        rd_out;
  logic                              wr_gpr, wr_pc;

  assign rd_arch[0]      = rd_a_idx;
  assign rd_arch[1]      = rd_b_idx;
  assign arch_idx[NRD-1:0] = rd_arch;
  assign arch_idx[NRD]   = wr_idx;
  assign arch_idx[NRD+1] = 4'd14;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rb_bank_map #(.REDUCED_FIQ(REDUCED_FIQ)) map_i (
      .mode     (mode),
      .arch_idx (arch_idx[m]),
      .phys_idx (phys_idx[m])
    );
  end

  assign rd_phys = phys_idx[NRD-1:0];
  assign wr_pc   = wr_en && (wr_idx == 4'd15);
  assign wr_gpr  = wr_en && (wr_idx != 4'd15);

  rb_gpr_store #(.DW(WORD_W), .NPHYS(RB_NPHYS), .NRD(NRD)) store_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wa_en   (wr_gpr),
    .wa_idx  (phys_idx[NRD]),
    .wa_data (wr_data),
    .wb_en   (br_en && br_link),
    .wb_idx  (phys_idx[NRD+1]),
    .wb_data (link_word),
    .rd_idx  (rd_phys),
    .rd_data (rd_store)
  );

  rb_r15_ctrl #(.ADDR_W(ADDR_W)) r15_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_pc),
    .wr_data    (wr_data),
    .pc_inc     (pc_inc),
    .br_en      (br_en),
    .br_word    (br_word),
    .flag_en    (flag_en),
    .flag_in    (flag_in),
    .mreq_en    (mode_req_en),
    .mreq       (mode_req),
    .r15_word   (r15_word),
    .link_word  (link_word),
    .fetch_addr (fetch_addr),
    .mode       (mode)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rdmux
    assign rd_out[p] = (rd_arch[p] == 4'd15) ? r15_word : rd_store[p];
  end

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
  assign cur_mode  = mode;

  // a mode change never lands in the same cycle as a user-mode request
  assert_mode_req_blocked_R6 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_USR && mode_req_en && mode_req != 2'b00) |=> (cur_mode == 2'b00));

endmodule

// File: tb/moded_regbank_tb_top.sv
`timescale 1ns/1ps
module moded_regbank_tb_top;

  localparam bit REDUCED_FIQ = 1'b0;
  localparam int FIQ_FIRST   = REDUCED_FIQ ? 10 : 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, fetch_addr;
  logic        wr_en, pc_inc, br_en, br_link, flag_en, mode_req_en;
  logic [23:0] br_word;
  logic [5:0]  flag_in;
  logic [1:0]  mode_req, cur_mode;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] m_usr [15];
  logic [31:0] m_fiq [7];
  logic [31:0] m_irq [2];
  logic [31:0] m_svc [2];
  logic [1:0]  m_mode;
  logic [3:0]  m_nzcv;
  logic [1:0]  m_if;
  logic [23:0] m_pc;

  always #2.5 clk = ~clk;

  moded_regbank #(.ADDR_W(26), .REDUCED_FIQ(REDUCED_FIQ)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_inc(pc_inc), .br_en(br_en), .br_link(br_link), .br_word(br_word),
    .flag_en(flag_en), .flag_in(flag_in),
    .mode_req_en(mode_req_en), .mode_req(mode_req),
    .fetch_addr(fetch_addr), .cur_mode(cur_mode)
  );

  function automatic logic [31:0] mdl_get(input logic [3:0] idx);
    int i = int'(idx);
    if (i == 15) return {m_nzcv, m_if, m_pc, m_mode};
    if (m_mode == 2'd1 && i >= 13) return m_irq[i-13];
    if (m_mode == 2'd3 && i >= 13) return m_svc[i-13];
    if (m_mode == 2'd2 && i >= FIQ_FIRST) return m_fiq[i-8];
    return m_usr[i];
  endfunction

  task automatic mdl_put(input logic [1:0] md, input int i, input logic [31:0] v);
    if (md == 2'd1 && i >= 13)             m_irq[i-13] = v;
    else if (md == 2'd3 && i >= 13)        m_svc[i-13] = v;
    else if (md == 2'd2 && i >= FIQ_FIRST) m_fiq[i-8]  = v;
    else                                   m_usr[i]    = v;
  endtask

  task automatic mdl_update();
    logic [1:0]  md = m_mode;
    logic [31:0] lv = {m_nzcv, m_if, m_pc + 24'd1, m_mode};
    if (br_en && br_link) mdl_put(md, 14, lv);
    if (wr_en && wr_idx != 4'd15) mdl_put(md, int'(wr_idx), wr_data);
    if (wr_en && wr_idx == 4'd15) begin
      m_pc   = wr_data[25:2];
      m_nzcv = wr_data[31:28];
      if (md != 2'd0) begin
        m_if   = wr_data[27:26];
        m_mode = wr_data[1:0];
      end
    end else begin
      if (br_en)       m_pc = br_word;
      else if (pc_inc) m_pc = m_pc + 24'd1;
      if (flag_en) begin
        m_nzcv = flag_in[5:2];
        if (md != 2'd0) m_if = flag_in[1:0];
      end
      if (mode_req_en && md != 2'd0) m_mode = mode_req;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_data = 0; pc_inc = 0; br_en = 0; br_link = 0;
    br_word = 0; flag_en = 0; flag_in = 0; mode_req_en = 0; mode_req = 0;
  endtask

  // called at a falling edge with inputs already set
  task automatic step(input string tag, input int ra, input int rb);
    rd_a_idx = 4'(ra);
    rd_b_idx = 4'(rb);
    #1;
    chk(tag, "rd_a", rd_a_data, mdl_get(rd_a_idx));
    chk(tag, "rd_b", rd_b_data, mdl_get(rd_b_idx));
    chk("R3", "fetch_addr", fetch_addr, {6'b0, m_pc, 2'b00});
    chk("R2", "cur_mode", {30'b0, cur_mode}, {30'b0, m_mode});
    @(posedge clk);
    mdl_update();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
  endtask

  task automatic rnd_step(input bit priv_only);
    wr_en   = ($urandom_range(2) == 0);
    wr_idx  = 4'($urandom_range(15));
    wr_data = $urandom;
    if (priv_only) wr_data[1:0] = 2'($urandom_range(3, 1));
    pc_inc  = 1'($urandom_range(1));
    br_en   = ($urandom_range(5) == 0);
    br_link = 1'($urandom_range(1));
    br_word = 24'($urandom);
    flag_en = ($urandom_range(3) == 0);
    flag_in = 6'($urandom);
    mode_req_en = ($urandom_range(4) == 0);
    mode_req = priv_only ? 2'($urandom_range(3, 1)) : 2'($urandom_range(3));
    step("R12", $urandom_range(15), $urandom_range(15));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++)  m_fiq[i] = '0;
    for (int i = 0; i < 2; i++) begin m_irq[i] = '0; m_svc[i] = '0; end
    m_mode = 2'd3; m_nzcv = 4'd0; m_if = 2'b11; m_pc = 24'd0;
    idle();
    rd_a_idx = 0; rd_b_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    step("R1", 15, 0);
    step("R1", 13, 14);

    // R4 supervisor and interrupt stacks
    wr(13, 32'h5A5A_0013); step("R4", 13, 14);
    wr(14, 32'h5A5A_0014); step("R4", 13, 14);
    mode_req_en = 1; mode_req = 2'd1; step("R4", 13, 14);
    wr(13, 32'h1111_0013); step("R4", 13, 12);
    mode_req_en = 1; mode_req = 2'd3; step("R4", 13, 14);

    // R5 fast-interrupt bank boundary
    wr(8, 32'h0000_0808); step("R5", 8, 9);
    mode_req_en = 1; mode_req = 2'd2; step("R5", 8, 13);
    wr(8, 32'hF1F1_0008); step("R5", 8, 7);
    wr(9, 32'hF1F1_0009); step("R5", 9, 8);
    wr(12, 32'hF1F1_0012); step("R5", 12, 14);
    mode_req_en = 1; mode_req = 2'd3; step("R5", 8, 12);
    step("R5", 9, 13);

    // R2 packed layout
    flag_en = 1; flag_in = 6'b101001; step("R2", 15, 14);
    pc_inc = 1; step("R2", 15, 0);

    // R8 branch with link in interrupt mode
    mode_req_en = 1; mode_req = 2'd1; step("R8", 15, 14);
    pc_inc = 1; step("R8", 15, 14);
    br_en = 1; br_link = 1; br_word = 24'h00_1234; step("R8", 15, 14);
    step("R8", 14, 15);
    br_en = 1; br_word = 24'hFF_FFFF; step("R8", 15, 14);

    // R9 priority and wrap
    pc_inc = 1; step("R9", 15, 14);
    wr(15, 32'h0ABC_DEF1); pc_inc = 1; br_en = 1; br_word = 24'h00_0055; step("R9", 15, 0);
    br_en = 1; pc_inc = 1; br_word = 24'h00_0077; step("R9", 15, 0);

    // R10 banking follows the mode at the start of the cycle
    wr(15, 32'h0000_0102); step("R10", 15, 13);
    wr(13, 32'hCAFE_0013); step("R10", 13, 15);
    mode_req_en = 1; mode_req = 2'd1; wr(13, 32'hBEEF_0013); step("R10", 13, 14);
    step("R10", 13, 14);
    mode_req_en = 1; mode_req = 2'd2; step("R10", 13, 14);

    // R11 explicit write beats link and flag/mode requests
    br_en = 1; br_link = 1; br_word = 24'h00_0300; wr(14, 32'h7777_0014); step("R11", 14, 15);
    step("R11", 14, 15);
    wr(15, 32'h4C00_0041); flag_en = 1; flag_in = 6'b111111; mode_req_en = 1; mode_req = 2'd3;
    step("R11", 15, 14);
    step("R11", 15, 13);

    for (int n = 0; n < 400; n++) rnd_step(1'b1);

    // drop into user mode, then try to escape
    mode_req_en = 1; mode_req = 2'd3; step("R6", 15, 13);
    flag_en = 1; flag_in = 6'b000011; step("R7", 15, 14);
    mode_req_en = 1; mode_req = 2'd0; step("R6", 15, 13);
    mode_req_en = 1; mode_req = 2'd3; step("R6", 15, 13);
    step("R6", 13, 14);
    wr(15, 32'hF000_0403); step("R6", 15, 13);
    wr(15, 32'h0000_0400); step("R7", 15, 14);
    flag_en = 1; flag_in = 6'b010100; step("R7", 15, 8);
    step("R7", 15, 9);

    for (int n = 0; n < 400; n++) rnd_step(1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule